// File: doc/BRIEF.md
# Framed Message Mailbox

This block moves one fixed-length software message per transport frame across a link and uses a handshake so that the far receiver never loses an unread message. It has two sides. The sending side holds a message buffer, a send command and a ready flag. The receiving side holds a message buffer and a full flag. A small control byte at the head of every channel slot carries two things: a marker for a message in the slot, and a free token for the local receive buffer. The free token is a bit that toggles each time software empties that buffer.

Software reaches both buffers and a status/command register through one byte-wide register port. Address map: transmit bytes at 0..7, receive bytes at 8..15, status/command at 16. A read of the status register returns bit 0 = transmit ready and bit 1 = receive full. A write with bit 0 set requests a send. The framing layer pulses `frame_start` once per frame. The block answers with a slot of 1 + 8 bytes on consecutive cycles. The incoming slot arrives in the same format on the `ch_in_*` pins.

Transmit FSM: TX_READY goes to TX_ARMED on a send command. TX_ARMED goes to TX_SEND at a frame start while the far buffer is known free. TX_SEND goes back to TX_READY on the last data byte. Receive FSM: RX_EMPTY goes to RX_LOAD on a control byte with its message marker set. RX_LOAD goes to RX_FULL on the eighth data byte. RX_FULL goes to RX_EMPTY when software reads the last receive byte. A marked control byte seen in RX_LOAD restarts the load.

Top module: `mbx_link`

## Requirements
- R1: After reset the transmit ready flag is 1, the receive full flag is 0, the channel output is idle (valid 0), and the status register reads 0x01.
- R2: Each accepted `frame_start` yields a control byte with `ch_out_sof`=1 on the next cycle, then exactly 8 data bytes (byte 0 first) on the following cycles. In the control byte, bit 0 marks a message, bit 1 carries the local free token, and bits 7:2 are 0. The data bytes are 0 when no message is carried. Data bytes that follow an unmarked control byte are never stored.
- R3: A send command while ready clears the ready flag. The message leaves in the next frame that is allowed to carry it. Ready sets again on the same edge that puts data byte 7 on the channel, and not before.
- R4: After a message is sent, no further message is sent until the incoming free token has changed. The held message then goes out at the first frame start after that change is seen.
- R5: While ready is 0, software writes to the transmit buffer and further send commands are ignored.
- R6: The receive full flag sets once the 8th data byte of a marked slot is stored. A marked slot that arrives while full is discarded and leaves the buffer unchanged.
- R7: A read of the last receive byte (address 15) while full clears the full flag and toggles the local free token. The new token appears in the next outgoing control byte.
- R8: All 16 buffer bytes read back through the register port, and software may write them (transmit bytes only while ready). Status bits are read-only, and a control write with bit 0 clear changes nothing.
- R9: A `frame_start` that arrives while a slot is still being emitted is ignored. The slot keeps its length and no second control byte is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | One-cycle frame strobe from the framing layer |
| sw_wr | input | 1 | Register write strobe |
| sw_rd | input | 1 | Register read strobe (side effect on address 15) |
| sw_addr | input | 5 | Register address |
| sw_wdata | input | 8 | Register write data |
| sw_rdata | output | 8 | Register read data (combinational) |
| tx_ready | output | 1 | Transmit buffer may be written |
| rx_full | output | 1 | Receive buffer holds an unread message |
| ch_out_valid | output | 1 | Outgoing slot byte valid |
| ch_out_sof | output | 1 | Outgoing byte is the control byte |
| ch_out_data | output | 8 | Outgoing slot byte |
| ch_in_valid | input | 1 | Incoming slot byte valid |
| ch_in_sof | input | 1 | Incoming byte is the control byte |
| ch_in_data | input | 8 | Incoming slot byte |

## Verification
The bench builds the block with its default message length of 8 bytes. That gives the 5-bit address map and a 9-cycle slot, so one frame of traffic fits in a few dozen cycles. Most scenarios loop the channel output straight back into the input, so a full round of the token handshake runs on one instance: send, hold while full, software release, token return, and release of the held message. For the receive-side discard and unmarked-slot cases the loop is opened and slots are driven directly.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic [1:0] {
        TX_READY,
        TX_ARMED,
        TX_SEND
    } tx_state_t;

    typedef enum logic [1:0] {
        RX_EMPTY,
        RX_LOAD,
        RX_FULL
    } rx_state_t;

    // control byte layout at the head of each slot
    localparam int CTL_MSG_BIT = 0;
    localparam int CTL_TOK_BIT = 1;

    // status / command register layout
    localparam int STAT_READY_BIT = 0;
    localparam int STAT_FULL_BIT  = 1;
    localparam int CMD_SEND_BIT   = 0;

endpackage

// File: rtl/mbx_tx.sv
module mbx_tx
    import mbx_pkg::*;
#(
    parameter int MSG_BYTES = 8,
    localparam int IDX_W = (MSG_BYTES > 1) ? $clog2(MSG_BYTES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic             send_req,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data,
    input  logic             peer_tok,
    input  logic             local_tok,
    output logic             ready,
    output logic             ch_valid,
    output logic             ch_sof,
    output logic [7:0]       ch_data
);

    tx_state_t        state_q, state_d;
    logic             slot_act_q;
    logic [IDX_W-1:0] slot_idx_q;
    logic             carry_q;
    logic             busy_q;
    logic             tok_ref_q;
    logic [7:0]       buf_q [MSG_BYTES];

    logic             frame_go;
    logic             launch;
    logic             last_byte;
    logic [7:0]       ctl_byte;

    assign frame_go  = frame_start && !slot_act_q;
    assign launch    = frame_go && (state_q == TX_ARMED) && !busy_q;
    assign last_byte = slot_act_q && (slot_idx_q == IDX_W'(MSG_BYTES - 1));
    assign ready     = (state_q == TX_READY);
    assign rd_data   = buf_q[rd_idx];

    always_comb begin
        ctl_byte = '0;
        ctl_byte[CTL_MSG_BIT] = launch;
        ctl_byte[CTL_TOK_BIT] = local_tok;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_READY: if (send_req) state_d = TX_ARMED;
            TX_ARMED: if (launch)   state_d = TX_SEND;
            TX_SEND:  if (last_byte && carry_q) state_d = TX_READY;
            default:  state_d = TX_READY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_READY;
        else        state_q <= state_d;
    end

    // slot emission, credit and buffer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_act_q <= 1'b0;
            slot_idx_q <= '0;
            carry_q    <= 1'b0;
            busy_q     <= 1'b0;
            tok_ref_q  <= 1'b0;
            ch_valid   <= 1'b0;
            ch_sof     <= 1'b0;
            ch_data    <= '0;
            for (int i = 0; i < MSG_BYTES; i++) buf_q[i] <= '0;
        end else begin
            if (frame_go) begin
                slot_act_q <= 1'b1;
                slot_idx_q <= '0;
                carry_q    <= launch;
                ch_valid   <= 1'b1;
                ch_sof     <= 1'b1;
                ch_data    <= ctl_byte;
            end else if (slot_act_q) begin
                ch_valid   <= 1'b1;
                ch_sof     <= 1'b0;
                ch_data    <= carry_q ? buf_q[slot_idx_q] : 8'h00;
                slot_idx_q <= slot_idx_q + 1'b1;
                if (last_byte) slot_act_q <= 1'b0;
            end else begin
                ch_valid <= 1'b0;
                ch_sof   <= 1'b0;
                ch_data  <= '0;
            end

            if (launch) begin
                busy_q    <= 1'b1;
                tok_ref_q <= peer_tok;
            end else if (busy_q && (peer_tok != tok_ref_q)) begin
                busy_q <= 1'b0;
            end

            if (wr_en && (state_q == TX_READY)) buf_q[wr_idx] <= wr_data;
        end
    end

endmodule

// File: rtl/mbx_rx.sv
module mbx_rx
    import mbx_pkg::*;
#(
    parameter int MSG_BYTES = 8,
    localparam int IDX_W = (MSG_BYTES > 1) ? $clog2(MSG_BYTES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ch_valid,
    input  logic             ch_sof,
    input  logic [7:0]       ch_data,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data,
    input  logic             rd_last,
    output logic             full,
    output logic             free_tok,
    output logic             peer_tok
);

    rx_state_t        state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic [7:0]       buf_q [MSG_BYTES];

    logic sof_in, msg_in, byte_in, load_byte, load_last, release_buf;

    assign sof_in      = ch_valid && ch_sof;
    assign msg_in      = sof_in && ch_data[CTL_MSG_BIT];
    assign byte_in     = ch_valid && !ch_sof;
    assign load_byte   = (state_q == RX_LOAD) && byte_in;
    assign load_last   = load_byte && (idx_q == IDX_W'(MSG_BYTES - 1));
    assign release_buf = (state_q == RX_FULL) && rd_last;
    assign full        = (state_q == RX_FULL);
    assign rd_data     = buf_q[rd_idx];

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_EMPTY: if (msg_in) state_d = RX_LOAD;
            RX_LOAD: begin
                if (msg_in)         state_d = RX_LOAD;
                else if (load_last) state_d = RX_FULL;
            end
            RX_FULL:  if (release_buf) state_d = RX_EMPTY;
            default:  state_d = RX_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_EMPTY;
        else        state_q <= state_d;
    end

    // buffer, byte index and tokens
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q    <= '0;
            free_tok <= 1'b0;
            peer_tok <= 1'b0;
            for (int i = 0; i < MSG_BYTES; i++) buf_q[i] <= '0;
        end else begin
            if (msg_in)         idx_q <= '0;
            else if (load_byte) idx_q <= idx_q + 1'b1;

            if (load_byte)   buf_q[idx_q]  <= ch_data;
            else if (wr_en)  buf_q[wr_idx] <= wr_data;

            if (sof_in)      peer_tok <= ch_data[CTL_TOK_BIT];
            if (release_buf) free_tok <= ~free_tok;
        end
    end

endmodule

// File: rtl/mbx_link.sv
module mbx_link
    import mbx_pkg::*;
#(
    parameter int MSG_BYTES = 8,
    localparam int IDX_W  = (MSG_BYTES > 1) ? $clog2(MSG_BYTES) : 1,
    localparam int ADDR_W = $clog2(2 * MSG_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              sw_wr,
    input  logic              sw_rd,
    input  logic [ADDR_W-1:0] sw_addr,
    input  logic [7:0]        sw_wdata,
    output logic [7:0]        sw_rdata,
    output logic              tx_ready,
    output logic              rx_full,
    output logic              ch_out_valid,
    output logic              ch_out_sof,
    output logic [7:0]        ch_out_data,
    input  logic              ch_in_valid,
    input  logic              ch_in_sof,
    input  logic [7:0]        ch_in_data
);

    localparam logic [ADDR_W-1:0] RX_BASE   = ADDR_W'(MSG_BYTES);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(2 * MSG_BYTES);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(2 * MSG_BYTES - 1);

    logic             sel_tx, sel_rx, sel_ctrl;
    logic [IDX_W-1:0] tx_idx, rx_idx;
    logic [7:0]       tx_rd, rx_rd;
    logic             free_tok, peer_tok;

    assign sel_tx   = (sw_addr < RX_BASE);
    assign sel_rx   = (sw_addr >= RX_BASE) && (sw_addr < CTRL_ADDR);
    assign sel_ctrl = (sw_addr == CTRL_ADDR);
    assign tx_idx   = sw_addr[IDX_W-1:0];
    assign rx_idx   = IDX_W'(sw_addr - RX_BASE);

    mbx_tx #(.MSG_BYTES(MSG_BYTES)) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .wr_en       (sw_wr && sel_tx),
        .wr_idx      (tx_idx),
        .wr_data     (sw_wdata),
        .send_req    (sw_wr && sel_ctrl && sw_wdata[CMD_SEND_BIT]),
        .rd_idx      (tx_idx),
        .rd_data     (tx_rd),
        .peer_tok    (peer_tok),
        .local_tok   (free_tok),
        .ready       (tx_ready),
        .ch_valid    (ch_out_valid),
        .ch_sof      (ch_out_sof),
        .ch_data     (ch_out_data)
    );

    mbx_rx #(.MSG_BYTES(MSG_BYTES)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .ch_valid (ch_in_valid),
        .ch_sof   (ch_in_sof),
        .ch_data  (ch_in_data),
        .wr_en    (sw_wr && sel_rx),
        .wr_idx   (rx_idx),
        .wr_data  (sw_wdata),
        .rd_idx   (rx_idx),
        .rd_data  (rx_rd),
        .rd_last  (sw_rd && (sw_addr == LAST_ADDR)),
        .full     (rx_full),
        .free_tok (free_tok),
        .peer_tok (peer_tok)
    );

    always_comb begin
        sw_rdata = '0;
        if (sel_tx) begin
            sw_rdata = tx_rd;
        end else if (sel_rx) begin
            sw_rdata = rx_rd;
        end else if (sel_ctrl) begin
            sw_rdata[STAT_READY_BIT] = tx_ready;
            sw_rdata[STAT_FULL_BIT]  = rx_full;
        end
    end

endmodule

// File: rtl/mbx_link_checker.sv
module mbx_link_checker #(
    parameter int MSG_BYTES = 8,
    localparam int ADDR_W = $clog2(2 * MSG_BYTES + 1),
    localparam int CNT_W  = $clog2(MSG_BYTES + 2)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sw_wr,
    input logic              sw_rd,
    input logic [ADDR_W-1:0] sw_addr,
    input logic              send_bit,
    input logic              tx_ready,
    input logic              rx_full,
    input logic              ch_out_valid,
    input logic              ch_out_sof,
    input logic              ch_in_valid,
    input logic              ch_in_sof
);

    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(2 * MSG_BYTES);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(2 * MSG_BYTES - 1);

    logic [CNT_W-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             run_cnt <= '0;
        else if (ch_out_sof)    run_cnt <= '0;
        else if (ch_out_valid)  run_cnt <= run_cnt + 1'b1;
        else                    run_cnt <= '0;
    end

    assert_sof_then_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ch_out_sof |=> (ch_out_valid && !ch_out_sof));

    assert_ready_on_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_ready) |-> (ch_out_valid && !ch_out_sof));

    assert_send_clears_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready && sw_wr && (sw_addr == CTRL_ADDR) && send_bit) |=> !tx_ready);

    assert_full_from_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full) |-> $past(ch_in_valid && !ch_in_sof));

    assert_full_clear_by_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_full) |-> $past(sw_rd && (sw_addr == LAST_ADDR)));

    assert_no_early_sof_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ch_out_sof |-> ((run_cnt == '0) || (run_cnt == CNT_W'(MSG_BYTES))));

endmodule

bind mbx_link mbx_link_checker #(.MSG_BYTES(MSG_BYTES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sw_wr        (sw_wr),
    .sw_rd        (sw_rd),
    .sw_addr      (sw_addr),
    .send_bit     (sw_wdata[0]),
    .tx_ready     (tx_ready),
    .rx_full      (rx_full),
    .ch_out_valid (ch_out_valid),
    .ch_out_sof   (ch_out_sof),
    .ch_in_valid  (ch_in_valid),
    .ch_in_sof    (ch_in_sof)
);

// File: tb/mbx_link_bench.sv
module mbx_link_bench;

    localparam int MSG    = 8;
    localparam int ADDR_W = $clog2(2 * MSG + 1);
    localparam int RXB    = MSG;
    localparam int CTRL   = 2 * MSG;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_start = 1'b0;
    logic sw_wr = 1'b0, sw_rd = 1'b0;
    logic [ADDR_W-1:0] sw_addr = '0;
    logic [7:0] sw_wdata = '0, sw_rdata;
    logic tx_ready, rx_full;
    logic ch_out_valid, ch_out_sof;
    logic [7:0] ch_out_data;
    logic loop_en = 1'b1;
    logic drv_valid = 1'b0, drv_sof = 1'b0;
    logic [7:0] drv_data = '0;
    logic ch_in_valid, ch_in_sof;
    logic [7:0] ch_in_data;

    assign ch_in_valid = loop_en ? ch_out_valid : drv_valid;
    assign ch_in_sof   = loop_en ? ch_out_sof   : drv_sof;
    assign ch_in_data  = loop_en ? ch_out_data  : drv_data;

    always #5 clk = ~clk;

    mbx_link #(.MSG_BYTES(MSG)) u_mbx_link (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .sw_wr(sw_wr), .sw_rd(sw_rd), .sw_addr(sw_addr),
        .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
        .tx_ready(tx_ready), .rx_full(rx_full),
        .ch_out_valid(ch_out_valid), .ch_out_sof(ch_out_sof), .ch_out_data(ch_out_data),
        .ch_in_valid(ch_in_valid), .ch_in_sof(ch_in_sof), .ch_in_data(ch_in_data)
    );

    int n_checks = 0;
    int n_errors = 0;

    logic [7:0] cap_ctrl;
    logic       cap_sof;
    logic [7:0] cap [MSG];
    logic       cap_ok_valid;
    logic       rdy_pre, rdy_post, after_valid, full_after;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic sw_write(input int a, input int d);
        @(negedge clk);
        sw_wr = 1'b1; sw_addr = ADDR_W'(a); sw_wdata = 8'(d);
        @(negedge clk);
        sw_wr = 1'b0;
    endtask

    task automatic sw_read(input int a, output logic [7:0] d);
        @(negedge clk);
        sw_addr = ADDR_W'(a); sw_rd = 1'b1;
        #1 d = sw_rdata;
        @(negedge clk);
        sw_rd = 1'b0;
    endtask

    task automatic run_frame(input bit mid);
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        cap_sof  = ch_out_sof;
        cap_ctrl = ch_out_data;
        cap_ok_valid = 1'b1;
        for (int k = 0; k < MSG; k++) begin
            @(negedge clk);
            frame_start = mid && (k == 2);
            cap[k] = ch_out_data;
            if (!(ch_out_valid && !ch_out_sof)) cap_ok_valid = 1'b0;
            if (k == MSG - 2) rdy_pre  = tx_ready;
            if (k == MSG - 1) rdy_post = tx_ready;
        end
        @(negedge clk);
        frame_start = 1'b0;
        after_valid = ch_out_valid;
        full_after  = rx_full;
    endtask

    task automatic drive_slot(input int ctl, input int base);
        @(negedge clk);
        drv_valid = 1'b1; drv_sof = 1'b1; drv_data = 8'(ctl);
        for (int k = 0; k < MSG; k++) begin
            @(negedge clk);
            drv_sof = 1'b0; drv_data = 8'(base + k);
        end
        @(negedge clk);
        drv_valid = 1'b0; drv_data = '0;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        chk("R1", "ready", tx_ready, 1);
        chk("R1", "full", rx_full, 0);
        chk("R1", "out valid", ch_out_valid, 0);
        sw_read(CTRL, d);
        chk("R1", "status", d, 8'h01);
    endtask

    task automatic t_idle_frame;
        run_frame(1'b0);
        chk("R2", "sof", cap_sof, 1);
        chk("R2", "control", cap_ctrl, 8'h00);
        chk("R2", "data valid run", cap_ok_valid, 1);
        for (int k = 0; k < MSG; k++) chk("R2", "idle byte", cap[k], 0);
        chk("R2", "slot end", after_valid, 0);
        chk("R2", "unmarked not stored", full_after, 0);
    endtask

    task automatic t_regs;
        logic [7:0] d;
        for (int k = 0; k < MSG; k++) sw_write(k, 8'hA0 + k);
        for (int k = 0; k < MSG; k++) begin
            sw_read(k, d);
            chk("R8", "tx byte", d, 8'hA0 + k);
        end
        sw_write(RXB + 2, 8'h5A);
        sw_read(RXB + 2, d);
        chk("R8", "rx byte write", d, 8'h5A);
        sw_write(CTRL, 8'hFE);
        sw_read(CTRL, d);
        chk("R8", "status read-only", d, 8'h01);
    endtask

    task automatic t_send;
        logic [7:0] d;
        sw_write(CTRL, 8'h01);
        chk("R3", "ready after send", tx_ready, 0);
        sw_write(0, 8'hFF);
        sw_read(0, d);
        chk("R5", "tx write ignored", d, 8'hA0);
        run_frame(1'b0);
        chk("R3", "marked control", cap_ctrl, 8'h01);
        for (int k = 0; k < MSG; k++) chk("R3", "payload", cap[k], 8'hA0 + k);
        chk("R3", "ready before last", rdy_pre, 0);
        chk("R3", "ready with last", rdy_post, 1);
        chk("R6", "full after load", full_after, 1);
        for (int k = 0; k < MSG - 1; k++) begin
            sw_read(RXB + k, d);
            chk("R6", "rx byte", d, 8'hA0 + k);
        end
        chk("R7", "full kept", rx_full, 1);
    endtask

    task automatic t_hold;
        logic [7:0] d;
        for (int k = 0; k < MSG; k++) sw_write(k, 8'h50 + k);
        sw_write(CTRL, 8'h01);
        run_frame(1'b0);
        chk("R4", "held frame 1", cap_ctrl, 8'h00);
        chk("R4", "still not ready", rdy_post, 0);
        sw_write(1, 8'hEE);
        sw_write(CTRL, 8'h01);
        sw_read(RXB, d);
        chk("R6", "no overwrite", d, 8'hA0);
        sw_read(RXB + MSG - 1, d);
        chk("R7", "last byte", d, 8'hA7);
        chk("R7", "full cleared", rx_full, 0);
        run_frame(1'b0);
        chk("R7", "token in next control", cap_ctrl, 8'h02);
        chk("R4", "held frame 2", rdy_post, 0);
        run_frame(1'b0);
        chk("R4", "released control", cap_ctrl, 8'h03);
        for (int k = 0; k < MSG; k++) chk("R5", "payload unchanged", cap[k], 8'h50 + k);
        chk("R4", "ready after release", rdy_post, 1);
        chk("R6", "full again", full_after, 1);
        for (int k = 0; k < MSG; k++) begin
            sw_read(RXB + k, d);
            chk("R6", "rx second msg", d, 8'h50 + k);
        end
        chk("R7", "full cleared 2", rx_full, 0);
    endtask

    task automatic t_rx_guard;
        logic [7:0] d;
        loop_en = 1'b0;
        drive_slot(8'h00, 8'h10);
        chk("R2", "unmarked slot ignored", rx_full, 0);
        drive_slot(8'h01, 8'h30);
        chk("R6", "full on driven", rx_full, 1);
        drive_slot(8'h01, 8'hC0);
        chk("R6", "full kept", rx_full, 1);
        sw_read(RXB, d);
        chk("R6", "discard keeps byte0", d, 8'h30);
        sw_read(RXB + MSG - 1, d);
        chk("R6", "discard keeps byte7", d, 8'h37);
        chk("R7", "cleared", rx_full, 0);
        loop_en = 1'b1;
    endtask

    task automatic t_mid_pulse;
        run_frame(1'b1);
        chk("R9", "no marker", cap_ctrl[0], 0);
        chk("R9", "data run", cap_ok_valid, 1);
        chk("R9", "no extra slot", after_valid, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle_frame();
        t_regs();
        t_send();
        t_hold();
        t_rx_guard();
        t_mid_pulse();
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule